// File: doc/BRIEF.md
# Lane Mask Expander

The block turns a packed bit mask into a wide lane mask. One byte of a 64-bit source operand is picked by a byte-select input. Each of its low-order bits becomes a whole output chunk: all ones where the bit is 1 and all zeros where it is 0. A two-bit size code sets the chunk width to 8, 16, 32 or 64 bits. The output is 128 bits wide, so eight 16-bit chunks fit.

It undoes an OR-mode chunk collapse. Collapsing each chunk of the expanded mask to one bit, at the same chunk size, gives back the mask bits that were used. The result is registered: one cycle after a valid input, the mask appears together with an output valid strobe.

Top module: `lane_mask_expander`

## Requirements
- R1: When mask bit k is 1, output chunk k is all ones; when it is 0, chunk k is all zeros. Chunk k occupies bits k*W to k*W+W-1, where W is 8, 16, 32 or 64 for size codes 0, 1, 2 and 3.
- R2: The number of mask bits used is 128/W capped at 8: eight for size codes 0 and 1, four for code 2 and two for code 3. Output bits above the last used chunk are zero.
- R3: A byte select of s takes the mask bits from source bits 8s+7 down to 8s, so select 0 takes bits 7:0. The other source bytes have no effect on the output.
- R4: `out_valid` is `in_valid` delayed by one clock. `out_mask` takes the expanded value on the rising edge at which `in_valid` is high.
- R5: While `in_valid` is low, `out_mask` keeps its previous value whatever the other inputs do.
- R6: While `rst_n` is low, `out_valid` and `out_mask` are zero.
- R7: A source of 0x5a with select 0 gives 0x00ff00ffff00ff00 at size code 0 and 0x0000ffff0000ffffffff0000ffff0000 at size code 1.
- R8: An OR-collapse of `out_mask` at the same chunk size equals the selected source byte with its unused high bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operands are valid in this cycle |
| in_src | input | 64 | Source operand that holds the packed mask bytes |
| in_size | input | 2 | Chunk size code: 0=8, 1=16, 2=32, 3=64 bits |
| in_sel | input | 3 | Index of the source byte that supplies the mask bits |
| out_valid | output | 1 | `out_mask` holds a new result |
| out_mask | output | 128 | Expanded lane mask |

## Verification
The expander is driven with mask bytes of all zeros, all ones, the alternating values 0x5a and 0xa5, and the single-bit values 0x01 and 0x80, at every chunk size. The single-bit and full-byte values show whether chunk placement and the cut-off at the used-bit count are right. The alternating values catch lanes that are swapped or shifted. A source whose eight bytes all differ, swept through every select value, shows that only the addressed byte reaches the output. Round trips through an OR-collapse, together with stimulus while valid is low, confirm that the expansion can be reversed and that the register holds its value when no new operands arrive.

// File: rtl/lme_pkg.sv
package lme_pkg;
   // Chunk size codes; the numeric value is the log2 of the chunk width in bytes
   typedef enum logic [1:0] {
      CHUNK_8  = 2'd0,
      CHUNK_16 = 2'd1,
      CHUNK_32 = 2'd2,
      CHUNK_64 = 2'd3
   } chunk_size_e;

   localparam int unsigned MASK_BITS = 8;
   localparam int unsigned NUM_SIZES = 4;

   function automatic int unsigned used_bits(input int unsigned out_w, input int unsigned chunk_w);
      int unsigned n;
      n = out_w / chunk_w;
      return (n > MASK_BITS) ? MASK_BITS : n;
   endfunction
endpackage

// File: rtl/lme_byte_pick.sv
module lme_byte_pick #(
   parameter int unsigned SRC_W = 64,
   localparam int unsigned NBYTES = SRC_W / 8,
   localparam int unsigned SEL_W = $clog2(NBYTES)
) (
   input  logic [SRC_W-1:0] src,
   input  logic [SEL_W-1:0] sel,
   output logic [7:0]       mask_byte
);
   logic [7:0] lanes [NBYTES];

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      assign lanes[b] = src[b*8 +: 8];
   end

   assign mask_byte = lanes[sel];
endmodule

// File: rtl/lme_chunk_fanout.sv
module lme_chunk_fanout
   import lme_pkg::*;
#(
   parameter int unsigned OUT_W   = 128,
   parameter int unsigned CHUNK_W = 8,
   localparam int unsigned NCHUNK = OUT_W / CHUNK_W,
   localparam int unsigned NUSED  = used_bits(OUT_W, CHUNK_W)
) (
   input  logic [MASK_BITS-1:0] bits,
   output logic [OUT_W-1:0]     lanes
);
   if (OUT_W % CHUNK_W != 0) begin : g_bad_chunk
      $error("lme_chunk_fanout: OUT_W must be a multiple of CHUNK_W");
   end

   for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
      if (c < NUSED) begin : g_used
         assign lanes[c*CHUNK_W +: CHUNK_W] = {CHUNK_W{bits[c]}};
      end else begin : g_zero
         assign lanes[c*CHUNK_W +: CHUNK_W] = '0;
      end
   end

   if (NUSED < MASK_BITS) begin : g_spare
      logic unused_hi;
      assign unused_hi = |bits[MASK_BITS-1:NUSED];
   end
endmodule

// File: rtl/lane_mask_expander.sv
module lane_mask_expander
   import lme_pkg::*;
#(
   parameter int unsigned SRC_W = 64,
   parameter int unsigned OUT_W = 128,
   localparam int unsigned SEL_W = $clog2(SRC_W / 8)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [SRC_W-1:0] in_src,
   input  logic [1:0]       in_size,
   input  logic [SEL_W-1:0] in_sel,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_mask
);
   if (SRC_W % 8 != 0 || SRC_W < 16) begin : g_bad_src
      $error("lane_mask_expander: SRC_W must be a multiple of 8 and at least 16");
   end
   if ((SRC_W / 8) != (1 << SEL_W)) begin : g_bad_nbytes
      $error("lane_mask_expander: SRC_W/8 must be a power of two");
   end
   if (OUT_W % 64 != 0 || OUT_W < 64) begin : g_bad_out
      $error("lane_mask_expander: OUT_W must be a nonzero multiple of 64");
   end

   logic [MASK_BITS-1:0] mask_byte;
   logic [OUT_W-1:0]     by_size [NUM_SIZES];
   logic [OUT_W-1:0]     mask_d;

   lme_byte_pick #(.SRC_W(SRC_W)) i_pick (
      .src       (in_src),
      .sel       (in_sel),
      .mask_byte (mask_byte)
   );

   // One fan-out per chunk width, picked afterwards by the size code
   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      lme_chunk_fanout #(.OUT_W(OUT_W), .CHUNK_W(8 << g)) i_fan (
         .bits  (mask_byte),
         .lanes (by_size[g])
      );
   end

   assign mask_d = by_size[in_size];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mask  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_mask <= mask_d;
         end
      end
   end
endmodule

// File: rtl/lme_checker.sv
module lme_checker #(
   parameter int unsigned SRC_W = 64,
   parameter int unsigned OUT_W = 128,
   localparam int unsigned SEL_W = $clog2(SRC_W / 8)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [SRC_W-1:0] in_src,
   input logic [1:0]       in_size,
   input logic [SEL_W-1:0] in_sel,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_mask
);
   assert_valid_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_mask));

   assert_sel0_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sel == '0 && in_size == 2'd3)
      |=> (out_mask[63:0] == {64{$past(in_src[0])}}));

   for (genvar b = 0; b < OUT_W / 8; b++) begin : g_byte_chk
      assert_byte_uniform_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_size == 2'd0)
         |=> (out_mask[b*8 +: 8] == 8'h00 || out_mask[b*8 +: 8] == 8'hff));
   end

   if (OUT_W > 64) begin : g_upper_chk
      assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_size == 2'd0) |=> (out_mask[OUT_W-1:64] == '0));
   end
endmodule

bind lane_mask_expander lme_checker #(.SRC_W(SRC_W), .OUT_W(OUT_W)) i_lme_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_src    (in_src),
   .in_size   (in_size),
   .in_sel    (in_sel),
   .out_valid (out_valid),
   .out_mask  (out_mask)
);

// File: tb/test_lane_mask_expander.sv
`timescale 1ns/1ps
module test_lane_mask_expander;
   localparam int SRC_W = 64;
   localparam int OUT_W = 128;
   localparam time TCLK = 20ns;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [SRC_W-1:0] in_src = '0;
   logic [1:0]       in_size = '0;
   logic [2:0]       in_sel = '0;
   logic             out_valid;
   logic [OUT_W-1:0] out_mask;

   int n_chk = 0;
   int n_err = 0;

   always #(TCLK/2) clk = ~clk;

   lane_mask_expander #(.SRC_W(SRC_W), .OUT_W(OUT_W)) i_lane_mask_expander (
      .clk, .rst_n, .in_valid, .in_src, .in_size, .in_sel, .out_valid, .out_mask
   );

   // Expected value straight from R1/R2/R3
   function automatic logic [OUT_W-1:0] model(input logic [SRC_W-1:0] s,
                                              input logic [1:0] sz, input logic [2:0] sel);
      logic [7:0] b;
      logic [OUT_W-1:0] r;
      int cw, n;
      b = s[sel*8 +: 8];
      cw = 8 << sz;
      n = OUT_W / cw;
      if (n > 8) n = 8;
      r = '0;
      for (int i = 0; i < OUT_W; i++) if (i / cw < n) r[i] = b[i / cw];
      return r;
   endfunction

   function automatic logic [15:0] collapse_or(input logic [OUT_W-1:0] m, input logic [1:0] sz);
      logic [15:0] r;
      int cw;
      cw = 8 << sz;
      r = '0;
      for (int i = 0; i < OUT_W; i++) r[i / cw] = r[i / cw] | m[i];
      return r;
   endfunction

   task automatic check(input string req, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Present one operand for one cycle; returns at the negedge after the capturing edge
   task automatic expand_once(input logic [SRC_W-1:0] s, input logic [1:0] sz, input logic [2:0] sel);
      @(negedge clk);
      in_src = s; in_size = sz; in_sel = sel; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R6 reset valid", {127'b0, out_valid}, '0);
      check("R6 reset mask", out_mask, '0);
      expand_once(64'hff, 2'd1, 3'd0);
      rst_n = 1'b0;
      #1;
      check("R6 async reset valid", {127'b0, out_valid}, '0);
      check("R6 async reset mask", out_mask, '0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_examples;
      expand_once(64'h5a, 2'd0, 3'd0);
      check("R7 byte chunks 0x5a", out_mask, 128'h0000000000000000_00ff00ffff00ff00);
      expand_once(64'h5a, 2'd1, 3'd0);
      check("R7 16-bit chunks 0x5a", out_mask, 128'h0000ffff0000ffffffff0000ffff0000);
   endtask

   task automatic t_patterns;
      logic [7:0] pats [6] = '{8'h00, 8'hff, 8'h5a, 8'ha5, 8'h01, 8'h80};
      for (int p = 0; p < 6; p++) begin
         for (int sz = 0; sz < 4; sz++) begin
            expand_once({56'h0, pats[p]}, sz[1:0], 3'd0);
            check("R1/R2 pattern expansion", out_mask, model({56'h0, pats[p]}, sz[1:0], 3'd0));
         end
      end
      expand_once(64'hff, 2'd3, 3'd0);
      check("R2 two chunks at 64-bit", out_mask, {128{1'b1}});
      expand_once(64'hf0, 2'd2, 3'd0);
      check("R2 upper bits of byte unused at 32-bit", out_mask, '0);
      expand_once(64'hff, 2'd0, 3'd0);
      check("R2 byte chunks leave upper half zero", out_mask, {64'h0, {64{1'b1}}});
   endtask

   task automatic t_select;
      logic [SRC_W-1:0] s = 64'h0123_4567_89ab_cdef;
      for (int sel = 0; sel < 8; sel++) begin
         expand_once(s, 2'd0, sel[2:0]);
         check("R3 byte select", out_mask, model(s, 2'd0, sel[2:0]));
      end
      expand_once(64'hffff_ffff_ffff_ff00, 2'd1, 3'd0);
      check("R3 other bytes ignored", out_mask, '0);
      expand_once(64'h0000_0000_0000_00ff, 2'd1, 3'd1);
      check("R3 byte 0 ignored when sel=1", out_mask, '0);
   endtask

   task automatic t_latency;
      @(negedge clk);
      in_src = 64'h3c; in_size = 2'd1; in_sel = 3'd0; in_valid = 1'b1;
      #1;
      check("R4 no output before edge", {127'b0, out_valid}, '0);
      @(negedge clk);
      in_valid = 1'b0;
      check("R4 valid after one cycle", {127'b0, out_valid}, 128'd1);
      check("R4 mask after one cycle", out_mask, model(64'h3c, 2'd1, 3'd0));
      @(negedge clk);
      check("R4 valid drops", {127'b0, out_valid}, '0);
   endtask

   task automatic t_hold;
      logic [OUT_W-1:0] keep;
      expand_once(64'ha5, 2'd2, 3'd0);
      keep = out_mask;
      @(negedge clk);
      in_src = 64'hffff_ffff_ffff_ffff; in_size = 2'd0; in_sel = 3'd5;
      @(negedge clk);
      @(negedge clk);
      check("R5 mask held while not valid", out_mask, keep);
      check("R5 valid stays low", {127'b0, out_valid}, '0);
   endtask

   task automatic t_roundtrip;
      logic [7:0] b;
      for (int sz = 0; sz < 4; sz++) begin
         for (int v = 0; v < 256; v += 37) begin
            b = v[7:0];
            expand_once({48'h0, b, 8'h00}, sz[1:0], 3'd1);
            check("R8 OR-collapse round trip", {112'b0, collapse_or(out_mask, sz[1:0])},
                  {120'b0, (sz < 2) ? b : (sz == 2) ? (b & 8'h0f) : (b & 8'h03)});
         end
      end
   endtask

   initial begin
      #(TCLK * 200000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_examples();
      t_patterns();
      t_select();
      t_latency();
      t_hold();
      t_roundtrip();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule